// File: doc/BRIEF.md
# Microphone Capture Control and Sample FIFO

This block is the bus-facing control point of a multi-channel pulse-density microphone capture path. Decimated audio words arrive on a plain sample port with a valid strobe; the block stores them in a receive FIFO. A processor or DMA engine drains that FIFO through a data window in a small register map. A single-port 32-bit bus with a one-cycle registered read carries all register accesses. Storage registers for the path, clock and high-pass settings are kept here so that the filter blocks next to it can decode them.

The block also runs the receive path. Software starts and stops the path and can order a FIFO flush. A DMA read request is raised while enough words are waiting to cover one burst. Overflow of the FIFO and reads from an empty FIFO are recorded as sticky status flags, and a write-one-to-clear register resets them.

Top module: `mic_rx_ctrl`

## Requirements
- R1: After reset, every storage and status register reads 0, the version register reads its parameter value (default 0x0001_0200), dma_req is low and the FIFO is empty.
- R2: A read presents its data on bus_rdata in the cycle after the access. The registers and their offsets are: system control 0x00, path control 0x04 (writable mask 0x7C00_001F), clock control 0x0C (mask 0x2F), filter control 0x10 (mask 0xF), DMA control 0x18, interrupt enable 0x1C (mask 0x3), status clear 0x20 (reads 0), status 0x24, data window 0x30 and version 0x58. Any other offset reads 0.
- R3: System control bit 2 is the run bit. Samples presented while the run bit is 0 are not stored.
- R4: Writing 1 to system control bit 0 empties the FIFO at that write's clock edge. The bit always reads back 0.
- R5: A write to system control that changes the run bit from 1 to 0 also empties the FIFO, even when bit 0 is 0.
- R6: A read of the data window returns the oldest stored sample and removes it. Samples come out in arrival order.
- R7: A read of the data window while the FIFO is empty returns 0 and sets status bit 1 (underflow). The bit stays set until it is cleared.
- R8: A sample arriving while the FIFO holds FIFO_DEPTH words, with no data-window read in the same cycle, is dropped. It sets status bit 0 (overflow), which stays set until cleared. When a read and a sample coincide at full level, the sample is kept.
- R9: Writing 1 to bit 0 or bit 1 of the status clear register clears the matching status bit. If the same flag is set in the same cycle, the set wins.
- R10: DMA control bit 8 enables requests, and bits 6:0 hold the watermark minus one. dma_req is high exactly when requests are enabled, the run bit is 1 and the fill level is at least field+1.
- R11: Writes to the version and status registers have no effect.
- R12: A sample arriving in the same cycle as a FIFO flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after a read |
| smp_valid | input | 1 | Decimated sample present |
| smp_data | input | DATA_W | Decimated sample word |
| dma_req | output | 1 | DMA read request |

## Verification
The hardest state to reach is a full FIFO where a data-window read and a new sample land in the same cycle. The sample must be kept and no overflow raised. A related case is a status-clear write colliding with a fresh overflow. The bench reaches both by running the path and pushing more than FIFO_DEPTH samples. It then issues a data-window read and a status-clear write while smp_valid is held high. A queue-based model follows every cycle. Flush collisions are covered by holding smp_valid high during the flush write and the stop write.

// File: rtl/mic_rx_pkg.sv
package mic_rx_pkg;
  // register byte offsets (decoded by neighbouring logic and software)
  localparam int OFS_SYS  = 'h00;
  localparam int OFS_PATH = 'h04;
  localparam int OFS_CLK  = 'h0C;
  localparam int OFS_FILT = 'h10;
  localparam int OFS_DMA  = 'h18;
  localparam int OFS_IEN  = 'h1C;
  localparam int OFS_ICLR = 'h20;
  localparam int OFS_STS  = 'h24;
  localparam int OFS_DATA = 'h30;
  localparam int OFS_VER  = 'h58;

  // field positions
  localparam int SYS_RUN_BIT  = 2;
  localparam int SYS_FLUSH_BIT = 0;
  localparam int DMA_EN_BIT   = 8;
  localparam int STS_OVF_BIT  = 0;
  localparam int STS_UNF_BIT  = 1;

  // writable masks of the plain storage registers
  localparam logic [31:0] PATH_MASK = 32'h7C00_001F;
  localparam logic [31:0] CLK_MASK  = 32'h0000_002F;
  localparam logic [31:0] FILT_MASK = 32'h0000_000F;
  localparam logic [31:0] IEN_MASK  = 32'h0000_0003;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SYS, SEL_PATH, SEL_CLK, SEL_FILT, SEL_DMA,
    SEL_IEN, SEL_ICLR, SEL_STS, SEL_DATA, SEL_VER
  } reg_sel_e;

  typedef struct packed {
    logic unf;
    logic ovf;
  } sts_t;
endpackage

// File: rtl/mic_rx_fifo.sv
module mic_rx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
  localparam logic [LVL_W-1:0] LVL_MAX  = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (push) wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + PTR_ONE;
      if (pop)  rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + PTR_ONE;
      case ({push, pop})
        2'b10:   cnt_d = cnt_q + LVL_ONE;
        2'b01:   cnt_d = cnt_q - LVL_ONE;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr_q] <= din;
  end

  assign head  = mem[rd_ptr_q];
  assign level = cnt_q;
  assign full  = (cnt_q == LVL_MAX);
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/mic_rx_flow.sv
module mic_rx_flow #(
  parameter int LVL_W = 7,
  parameter int WM_W  = 7,
  localparam int CMP_W = ((LVL_W > WM_W) ? LVL_W : WM_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_wr,
  input  logic             wd_run,
  input  logic             wd_flush,
  input  logic             iclr_wr,
  input  logic             wd_clr_ovf,
  input  logic             wd_clr_unf,
  input  logic             data_rd,
  input  logic             smp_valid,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             dma_en,
  input  logic [WM_W-1:0]  dma_wm,
  output logic             run_q,
  output logic             fifo_clr,
  output logic             fifo_push,
  output logic             fifo_pop,
  output logic             ovf_q,
  output logic             unf_q,
  output logic             dma_req
);
  logic run_d, ovf_d, unf_d;
  logic smp_take, ovf_set, unf_set;
  logic [CMP_W-1:0] lvl_x, wm_x;

  // a flush is ordered explicitly or implied by a running-to-stopped write
  assign fifo_clr = sys_wr && (wd_flush || (run_q && !wd_run));
  assign fifo_pop = data_rd && !fifo_empty;
  assign smp_take = smp_valid && run_q && !fifo_clr;
  assign fifo_push = smp_take && (!fifo_full || fifo_pop);
  assign ovf_set  = smp_take && fifo_full && !fifo_pop;
  assign unf_set  = data_rd && fifo_empty;

  always_comb begin
    run_d = sys_wr ? wd_run : run_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (iclr_wr && wd_clr_ovf) ovf_d = 1'b0;
    if (iclr_wr && wd_clr_unf) unf_d = 1'b0;
    if (ovf_set) ovf_d = 1'b1;
    if (unf_set) unf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      run_q <= run_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  assign lvl_x   = CMP_W'(fifo_level);
  assign wm_x    = CMP_W'(dma_wm);
  assign dma_req = dma_en && run_q && (lvl_x > wm_x);
endmodule

// File: rtl/mic_rx_regs.sv
module mic_rx_regs
  import mic_rx_pkg::*;
#(
  parameter int          ADDR_W  = 8,
  parameter int          DATA_W  = 32,
  parameter int          WM_W    = 7,
  parameter logic [31:0] VERSION = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              run_q,
  input  logic              ovf_q,
  input  logic              unf_q,
  input  logic [DATA_W-1:0] fifo_head,
  input  logic              fifo_empty,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_wr,
  output logic              iclr_wr,
  output logic              data_rd,
  output logic              dma_en,
  output logic [WM_W-1:0]   dma_wm
);
  reg_sel_e sel;
  logic wr_en, rd_en;
  logic [DATA_W-1:0] path_q, path_d, clk_q, clk_d, filt_q, filt_d, ien_q, ien_d;
  logic [DATA_W-1:0] rd_val, rdata_q, rdata_d;
  logic              dma_en_q, dma_en_d;
  logic [WM_W-1:0]   dma_wm_q, dma_wm_d;
  sts_t              sts;

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFS_SYS):  sel = SEL_SYS;
      ADDR_W'(OFS_PATH): sel = SEL_PATH;
      ADDR_W'(OFS_CLK):  sel = SEL_CLK;
      ADDR_W'(OFS_FILT): sel = SEL_FILT;
      ADDR_W'(OFS_DMA):  sel = SEL_DMA;
      ADDR_W'(OFS_IEN):  sel = SEL_IEN;
      ADDR_W'(OFS_ICLR): sel = SEL_ICLR;
      ADDR_W'(OFS_STS):  sel = SEL_STS;
      ADDR_W'(OFS_DATA): sel = SEL_DATA;
      ADDR_W'(OFS_VER):  sel = SEL_VER;
      default:           sel = SEL_NONE;
    endcase
  end

  assign wr_en   = bus_sel && bus_wr;
  assign rd_en   = bus_sel && !bus_wr;
  assign sys_wr  = wr_en && (sel == SEL_SYS);
  assign iclr_wr = wr_en && (sel == SEL_ICLR);
  assign data_rd = rd_en && (sel == SEL_DATA);

  assign sts.ovf = ovf_q;
  assign sts.unf = unf_q;

  // storage register next state
  always_comb begin
    path_d   = path_q;
    clk_d    = clk_q;
    filt_d   = filt_q;
    ien_d    = ien_q;
    dma_en_d = dma_en_q;
    dma_wm_d = dma_wm_q;
    if (wr_en) begin
      case (sel)
        SEL_PATH: path_d = bus_wdata & DATA_W'(PATH_MASK);
        SEL_CLK:  clk_d  = bus_wdata & DATA_W'(CLK_MASK);
        SEL_FILT: filt_d = bus_wdata & DATA_W'(FILT_MASK);
        SEL_IEN:  ien_d  = bus_wdata & DATA_W'(IEN_MASK);
        SEL_DMA: begin
          dma_en_d = bus_wdata[DMA_EN_BIT];
          dma_wm_d = bus_wdata[WM_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rd_val = '0;
    case (sel)
      SEL_SYS:  rd_val[SYS_RUN_BIT] = run_q;
      SEL_PATH: rd_val = path_q;
      SEL_CLK:  rd_val = clk_q;
      SEL_FILT: rd_val = filt_q;
      SEL_DMA: begin
        rd_val[DMA_EN_BIT] = dma_en_q;
        rd_val[WM_W-1:0]   = dma_wm_q;
      end
      SEL_IEN:  rd_val = ien_q;
      SEL_STS: begin
        rd_val[STS_OVF_BIT] = sts.ovf;
        rd_val[STS_UNF_BIT] = sts.unf;
      end
      SEL_DATA: rd_val = fifo_empty ? '0 : fifo_head;
      SEL_VER:  rd_val = DATA_W'(VERSION);
      default:  rd_val = '0;
    endcase
    rdata_d = rd_en ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      path_q   <= '0;
      clk_q    <= '0;
      filt_q   <= '0;
      ien_q    <= '0;
      dma_en_q <= 1'b0;
      dma_wm_q <= '0;
      rdata_q  <= '0;
    end else begin
      path_q   <= path_d;
      clk_q    <= clk_d;
      filt_q   <= filt_d;
      ien_q    <= ien_d;
      dma_en_q <= dma_en_d;
      dma_wm_q <= dma_wm_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign dma_en    = dma_en_q;
  assign dma_wm    = dma_wm_q;
endmodule

// File: rtl/mic_rx_ctrl.sv
module mic_rx_ctrl
  import mic_rx_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          FIFO_DEPTH = 64,
  parameter int          WM_W       = 7,
  parameter logic [31:0] VERSION    = 32'h0001_0200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  output logic              dma_req
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic              sys_wr, iclr_wr, data_rd;
  logic              dma_en;
  logic [WM_W-1:0]   dma_wm;
  logic              run_q, ovf_q, unf_q;
  logic              fifo_clr, fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [LVL_W-1:0]  fifo_level;
  logic [DATA_W-1:0] fifo_head;

  mic_rx_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WM_W(WM_W), .VERSION(VERSION)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .run_q(run_q), .ovf_q(ovf_q), .unf_q(unf_q),
    .fifo_head(fifo_head), .fifo_empty(fifo_empty),
    .bus_rdata(bus_rdata), .sys_wr(sys_wr), .iclr_wr(iclr_wr), .data_rd(data_rd),
    .dma_en(dma_en), .dma_wm(dma_wm)
  );

  mic_rx_flow #(.LVL_W(LVL_W), .WM_W(WM_W)) u_flow (
    .clk(clk), .rst_n(rst_n),
    .sys_wr(sys_wr),
    .wd_run(bus_wdata[SYS_RUN_BIT]), .wd_flush(bus_wdata[SYS_FLUSH_BIT]),
    .iclr_wr(iclr_wr),
    .wd_clr_ovf(bus_wdata[STS_OVF_BIT]), .wd_clr_unf(bus_wdata[STS_UNF_BIT]),
    .data_rd(data_rd), .smp_valid(smp_valid),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
    .dma_en(dma_en), .dma_wm(dma_wm),
    .run_q(run_q), .fifo_clr(fifo_clr), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .ovf_q(ovf_q), .unf_q(unf_q), .dma_req(dma_req)
  );

  mic_rx_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .clr(fifo_clr), .push(fifo_push), .pop(fifo_pop), .din(smp_data),
    .head(fifo_head), .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
  );
endmodule

// File: rtl/mic_rx_ctrl_chk.sv
module mic_rx_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LVL_W  = 7,
  parameter int DEPTH  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              smp_valid,
  input logic              dma_req,
  input logic              run_q,
  input logic              sys_wr,
  input logic              data_rd,
  input logic              fifo_clr,
  input logic              fifo_pop,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic [LVL_W-1:0]  fifo_level,
  input logic              ovf_q,
  input logic              unf_q
);
  localparam logic [LVL_W:0] LVL_ONE = (LVL_W+1)'(1);
  localparam logic [LVL_W:0] LVL_CAP = (LVL_W+1)'(DEPTH);

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, fifo_level} <= LVL_CAP);

  // R6
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_clr |=> ({1'b0, fifo_level} <= {1'b0, $past(fifo_level)} + LVL_ONE) &&
                  ({1'b0, fifo_level} + LVL_ONE >= {1'b0, $past(fifo_level)}));

  // R4
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_wr && bus_wdata[0]) |=> fifo_empty);

  // R4
  flush_bit_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == '0) |=> !bus_rdata[0]);

  // R5
  stop_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_wr && run_q && !bus_wdata[2]) |=> fifo_empty && !run_q);

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_empty) |=> (bus_rdata == '0) && unf_q);

  // R8
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && run_q && fifo_full && !fifo_pop && !fifo_clr) |=> ovf_q && fifo_full);

  // R10
  dma_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> !fifo_empty && run_q);
endmodule

bind mic_rx_ctrl mic_rx_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid), .dma_req(dma_req),
  .run_q(run_q), .sys_wr(sys_wr), .data_rd(data_rd), .fifo_clr(fifo_clr),
  .fifo_pop(fifo_pop), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .fifo_level(fifo_level), .ovf_q(ovf_q), .unf_q(unf_q)
);

// File: tb/mic_rx_ctrl_tb.sv
`timescale 1ns/1ps
module mic_rx_ctrl_tb;
  localparam int DEPTH = 64;
  localparam logic [31:0] VER = 32'h0001_0200;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_sel, bus_wr, smp_valid;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, smp_data, bus_rdata;
  logic dma_req;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [31:0] mq[$];
  bit          m_run, m_en, m_ovf, m_unf;
  logic [6:0]  m_wm;
  logic [31:0] m_path, m_clk, m_filt, m_ien, m_rdata;

  always #2.5 clk = ~clk;

  mic_rx_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .dma_req(dma_req)
  );

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h00: return {29'd0, m_run, 2'b00};
      8'h04: return m_path;
      8'h0C: return m_clk;
      8'h10: return m_filt;
      8'h18: return {23'd0, m_en, 1'b0, m_wm};
      8'h1C: return m_ien;
      8'h24: return {30'd0, m_unf, m_ovf};
      8'h30: return (mq.size() > 0) ? mq[0] : 32'd0;
      8'h58: return VER;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] exp, string tag, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(bit sel, bit wr, logic [7:0] a, logic [31:0] wd,
                     bit sv, logic [31:0] sd, string tag);
    bit flush, pop, take;
    bit ovf_set, unf_set;
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    smp_valid = sv; smp_data = sd;
    @(posedge clk);
    ovf_set = 0; unf_set = 0;
    flush = sel && wr && a == 8'h00 && (wd[0] || (m_run && !wd[2]));
    pop   = sel && !wr && a == 8'h30;
    take  = sv && m_run && !flush;
    if (sel && !wr) m_rdata = exp_read(a);
    if (flush) mq.delete();
    if (pop) begin
      if (mq.size() == 0) unf_set = 1;
      else void'(mq.pop_front());
    end
    if (take) begin
      if (mq.size() < DEPTH) mq.push_back(sd);
      else ovf_set = 1;
    end
    if (sel && wr) begin
      case (a)
        8'h00: m_run  = wd[2];
        8'h04: m_path = wd & 32'h7C00_001F;
        8'h0C: m_clk  = wd & 32'h0000_002F;
        8'h10: m_filt = wd & 32'h0000_000F;
        8'h18: begin m_en = wd[8]; m_wm = wd[6:0]; end
        8'h1C: m_ien  = wd & 32'h3;
        8'h20: begin if (wd[0]) m_ovf = 0; if (wd[1]) m_unf = 0; end
        default: ;
      endcase
    end
    if (ovf_set) m_ovf = 1;
    if (unf_set) m_unf = 1;
    #1;
    check(bus_rdata, m_rdata, tag, "rdata");
    check({31'd0, dma_req}, {31'd0, (m_en && m_run && mq.size() >= int'(m_wm) + 1)},
          "R10", "dma_req");
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string tag);
    cyc(1, 1, a, d, 0, 0, tag);
  endtask
  task automatic rd(logic [7:0] a, string tag);
    cyc(1, 0, a, 0, 0, 0, tag);
  endtask
  task automatic smp(logic [31:0] d, string tag);
    cyc(0, 0, 8'h00, 0, 1, d, tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; smp_valid = 0; smp_data = 0;
    m_run = 0; m_en = 0; m_ovf = 0; m_unf = 0; m_wm = 0;
    m_path = 0; m_clk = 0; m_filt = 0; m_ien = 0; m_rdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset values
    foreach (m_path[i]) if (i < 1) ;
    rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h0C, "R1"); rd(8'h10, "R1");
    rd(8'h18, "R1"); rd(8'h1C, "R1"); rd(8'h24, "R1"); rd(8'h58, "R1");

    // R2: masked storage, undefined offset, clear register reads 0
    wr(8'h04, 32'hFFFF_FFFF, "R2"); rd(8'h04, "R2");
    wr(8'h0C, 32'hFFFF_FFFF, "R2"); rd(8'h0C, "R2");
    wr(8'h10, 32'h1234_567A, "R2"); rd(8'h10, "R2");
    wr(8'h1C, 32'hFFFF_FFFE, "R2"); rd(8'h1C, "R2");
    wr(8'h40, 32'hDEAD_BEEF, "R2"); rd(8'h40, "R2"); rd(8'h20, "R2");

    // R11: read-only registers ignore writes
    wr(8'h58, 32'h0, "R11"); rd(8'h58, "R11");
    wr(8'h24, 32'h3, "R11"); rd(8'h24, "R11");

    // R3: samples while stopped are not stored; R7: empty read
    smp(32'hAAAA_0001, "R3"); smp(32'hAAAA_0002, "R3");
    rd(8'h30, "R7"); rd(8'h24, "R7");
    // R9: write-one clear of underflow
    wr(8'h20, 32'h2, "R9"); rd(8'h24, "R9");

    // R10: watermark field 3 -> request at 4 words; R6 ordering
    wr(8'h18, 32'h0000_0103, "R10");
    wr(8'h00, 32'h4, "R3");
    for (int i = 0; i < 5; i++) smp(32'h1000 + i, "R10");
    for (int i = 0; i < 5; i++) rd(8'h30, "R6");
    rd(8'h30, "R7"); rd(8'h24, "R7"); wr(8'h20, 32'h3, "R9");

    // R8: fill past capacity, overflow flag
    for (int i = 0; i < DEPTH + 2; i++) smp(32'h2000 + i, "R8");
    rd(8'h24, "R8");
    // R8: read and sample together at full level keep the sample
    cyc(1, 0, 8'h30, 0, 1, 32'h5555_0001, "R8");
    wr(8'h20, 32'h1, "R9"); rd(8'h24, "R9");
    // R9: set wins over a simultaneous clear
    cyc(1, 1, 8'h20, 32'h1, 1, 32'h5555_0002, "R9");
    rd(8'h24, "R9");
    for (int i = 0; i < DEPTH; i++) rd(8'h30, "R6");

    // R4 + R12: flush while running with a sample in the same cycle
    for (int i = 0; i < 6; i++) smp(32'h3000 + i, "R4");
    cyc(1, 1, 8'h00, 32'h5, 1, 32'h3FFF, "R12");
    rd(8'h00, "R4"); rd(8'h30, "R4"); wr(8'h20, 32'h3, "R9");

    // R5: stop empties the FIFO, sample in the stop cycle discarded
    wr(8'h18, 32'h0000_010F, "R10");
    for (int i = 0; i < 17; i++) smp(32'h4000 + i, "R10");
    cyc(1, 1, 8'h00, 32'h0, 1, 32'h4FFF, "R5");
    wr(8'h00, 32'h4, "R5"); rd(8'h30, "R5"); rd(8'h24, "R5");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule